// File: doc/BRIEF.md
# Dual Byte-Strobe DRAM Cycle Decoder

This block is the device-side front end of a 1M x 16 page-mode DRAM, rebuilt as synchronous logic that runs on a fast system clock. It watches the active-low row strobe, two active-low byte column strobes, write enable and output enable. All five are synchronised and edge-detected. From these it works out which cycle is in progress, captures the row and column halves of the 10-bit multiplexed address, and produces one output-enable and one write pulse for each byte lane. A small register array stands in for the cell array, so that written bytes can be read back.

The two byte strobes are merged into one internal column strobe. That strobe becomes active on the first lane to fall and stays active until the last lane has risen. Each lane still gates only its own byte. A row strobe that falls while a column strobe is already low starts a CAS-before-RAS refresh. In that cycle the row comes from an internal 10-bit counter and the address pins are ignored. The counter advances when the refresh cycle ends. No data lane is enabled during refresh.

Every output is registered. A pin change shows on the outputs after the synchroniser depth plus one clock, which is three clocks at the default settings.

Top module: `dram_strobe_frontend`

## Requirements
- R1: After a synchronous reset `cycle_type` is 0 (idle), and `lane_oe`, `lane_we`, `row_q` and `col_q` are all zero.
- R2: A falling `ras_n` while both column strobes are high copies `addr` into `row_q`, and `row_q` then holds its value until `ras_n` rises.
- R3: The column address is captured into `col_q` when the first byte strobe falls, and a second strobe falling later does not change it. The merged strobe keeps the cycle active until both `lcs_n` and `ucs_n` are high again.
- R4: Lane 0 (bits 7:0) is gated only by `lcs_n`, and lane 1 (bits 15:8) only by `ucs_n`, for both `lane_oe` and `lane_we`.
- R5: `lane_oe[i]` is high only while the row is open (not refresh), lane i's strobe is low, `oe_n` is low and `we_n` is high. `cycle_type` then reads 2 (read).
- R6: A write fires a one-clock `lane_we[i]` pulse at the later of lane i's strobe falling and `we_n` falling. It stores that lane's byte of `wdata` as sampled at that moment, and `cycle_type` reads 3 (write) while `we_n` and a strobe are low.
- R7: A falling `ras_n` while a column strobe is already low sets `cycle_type` to 4 (refresh) and loads `row_q` from the refresh counter, with `addr` ignored.
- R8: During refresh, `lane_oe` and `lane_we` stay zero whatever `oe_n` and `we_n` do.
- R9: The refresh counter starts at 0, rises by one as each refresh cycle ends, and wraps from 1023 to 0.
- R10: With the row open and a column strobe low, `cycle_type` reads 1 (row open, no access) when neither `we_n` nor `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcs_n | input | 1 | Lower byte column strobe, active low |
| ucs_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data from the stand-in array |
| lane_oe | output | 2 | Per-byte output drive enable |
| lane_we | output | 2 | Per-byte write pulse |
| cycle_type | output | 3 | 0 idle, 1 row open, 2 read, 3 write, 4 refresh |
| row_q | output | 10 | Captured row (or refresh row) |
| col_q | output | 10 | Captured column |

## Verification
The hardest case to reach is the refresh counter's wrap from 1023 to 0. Getting there needs more than a thousand refresh cycles in a row. The bench holds the lower strobe low and toggles only the row strobe to run through them quickly, checking the row at the first refreshes, at 1023 and after the wrap. The merged strobe is also hard to observe. The bench drops the two byte strobes at different times with a new address in between, then releases them one at a time, so that the first-fall capture and the last-rise end can be seen.

// File: rtl/dsf_pkg.sv
// Shared types for the dual byte-strobe DRAM front end.
// Assumes: cycle codes are read by neighbouring logic as plain 3-bit values.
package dsf_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_ROWOPEN = 3'd1,
        CYC_READ    = 3'd2,
        CYC_WRITE   = 3'd3,
        CYC_REFRESH = 3'd4
    } cyc_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_ROW  = 2'd1,
        M_RFSH = 2'd2
    } mode_e;

endpackage

// File: rtl/dsf_sync_edge.sv
// Multi-stage synchroniser for a vector of asynchronous levels, plus a one-clock
// delayed copy of the low EDGE_W bits for edge detection.
// Assumes: inputs are active-high levels; reset value of every stage is 0.
module dsf_sync_edge #(
    parameter int W       = 5,
    parameter int STAGES  = 2,
    parameter int EDGE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      din,
    output logic [W-1:0]      lvl,
    output logic [EDGE_W-1:0] prev
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din[b]};
        end

        assign lvl[b] = chain[STAGES-1];
    end

    // Hold last cycle's synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl[EDGE_W-1:0];
    end

endmodule

// File: rtl/dsf_refresh_ctr.sv
// Row counter used by CAS-before-RAS refresh; steps once per completed refresh.
// Assumes: natural binary wrap at 2**W.
module dsf_refresh_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] count
);

    // Advance the refresh row when a refresh cycle closes.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + 1'b1;
    end

endmodule

// File: rtl/dsf_lane_store.sv
// Small byte-laned register array standing in for the DRAM cells.
// Assumes: one index for read and write; read data registered every clock.
module dsf_lane_store #(
    parameter int IDX_W  = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_en,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Store this lane's byte on its write pulse.
        always_ff @(posedge clk) begin
            if (wr_en[l]) cells[idx] <= wdata[l*LANE_W +: LANE_W];
        end

        // Present the addressed byte one clock later.
        always_ff @(posedge clk) begin
            rdata[l*LANE_W +: LANE_W] <= cells[idx];
        end
    end

endmodule

// File: rtl/dram_strobe_frontend.sv
// Device-side decoder for a x16 page-mode DRAM with two byte column strobes.
// Synchronises the strobes, merges the byte strobes (first fall / last rise),
// captures row and column, detects CAS-before-RAS refresh, and drives per-lane
// output enables and write pulses. A small array stands in for the cells.
// Assumes: addr and wdata are stable around the strobe edges for at least
// SYNC_STAGES+1 clocks; a byte strobe never falls in the same clock as ras_n.
module dram_strobe_frontend
    import dsf_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int LANE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STORE_AW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n,
    input  logic                  lcs_n,
    input  logic                  ucs_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   wdata,
    output logic [2*LANE_W-1:0]   rdata,
    output logic [1:0]            lane_oe,
    output logic [1:0]            lane_we,
    output logic [2:0]            cycle_type,
    output logic [ADDR_W-1:0]     row_q,
    output logic [ADDR_W-1:0]     col_q
);

    localparam int NSIG = 5;
    localparam int NEDG = 4;
    localparam int RB   = STORE_AW / 2;
    localparam int CB   = STORE_AW - RB;

    logic [NSIG-1:0]   act;
    logic [NEDG-1:0]   act_d;
    logic              ras_act, we_act, oe_act;
    logic [1:0]        lane_act, lane_rise;
    logic              ras_rise, we_rise, cas_any, cas_prev, cas_rise, cbr;
    logic              row_open, rfsh_step;
    logic [1:0]        wr_fire, rd_en;
    logic [CB-1:0]     col_lo;
    logic [ADDR_W-1:0] rfsh_row;
    mode_e             mode, mode_nxt;
    cyc_e              cyc_q, cyc_nxt;

    // Bit order: 0 row strobe, 1 lower, 2 upper, 3 write, 4 output enable.
    dsf_sync_edge #(.W(NSIG), .STAGES(SYNC_STAGES), .EDGE_W(NEDG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({~oe_n, ~we_n, ~ucs_n, ~lcs_n, ~ras_n}),
        .lvl  (act),
        .prev (act_d)
    );

    assign ras_act   = act[0];
    assign lane_act  = act[2:1];
    assign we_act    = act[3];
    assign oe_act    = act[4];
    assign ras_rise  = act[0] & ~act_d[0];
    assign lane_rise = act[2:1] & ~act_d[2:1];
    assign we_rise   = act[3] & ~act_d[3];
    assign cas_any   = |lane_act;
    assign cas_prev  = |act_d[2:1];
    assign cas_rise  = cas_any & ~cas_prev;
    assign cbr       = ras_rise & cas_any & cas_prev;
    assign row_open  = (mode == M_ROW) && ras_act;
    assign rfsh_step = (mode == M_RFSH) && !ras_act;

    // Next operating mode from the row strobe and refresh detection.
    always_comb begin
        if (!ras_act)      mode_nxt = M_IDLE;
        else if (ras_rise) mode_nxt = cbr ? M_RFSH : M_ROW;
        else               mode_nxt = mode;
    end

    // Decode the reported cycle type from the next mode and current levels.
    always_comb begin
        case (mode_nxt)
            M_RFSH:  cyc_nxt = CYC_REFRESH;
            M_ROW: begin
                if (cas_any && we_act)      cyc_nxt = CYC_WRITE;
                else if (cas_any && oe_act) cyc_nxt = CYC_READ;
                else                        cyc_nxt = CYC_ROWOPEN;
            end
            default: cyc_nxt = CYC_IDLE;
        endcase
    end

    // Per-lane write triggers and read enables.
    for (genvar l = 0; l < 2; l++) begin : g_gate
        assign wr_fire[l] = row_open & lane_act[l] & we_act & (lane_rise[l] | we_rise);
        assign rd_en[l]   = row_open & lane_act[l] & oe_act & ~we_act;
    end

    // Column used by the array: fresh address on the merged strobe's fall.
    assign col_lo = (row_open && cas_rise) ? addr[CB-1:0] : col_q[CB-1:0];

    // Mode, address capture and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= M_IDLE;
            cyc_q   <= CYC_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            lane_oe <= '0;
            lane_we <= '0;
        end else begin
            mode    <= mode_nxt;
            cyc_q   <= cyc_nxt;
            lane_oe <= rd_en;
            lane_we <= wr_fire;
            if (ras_act && ras_rise) row_q <= cbr ? rfsh_row : addr;
            if (row_open && cas_rise) col_q <= addr;
        end
    end

    assign cycle_type = cyc_q;

    dsf_refresh_ctr #(.W(ADDR_W)) u_rfsh (
        .clk  (clk),
        .rst_n(rst_n),
        .step (rfsh_step),
        .count(rfsh_row)
    );

    dsf_lane_store #(.IDX_W(STORE_AW), .LANES(2), .LANE_W(LANE_W)) u_store (
        .clk  (clk),
        .wr_en(wr_fire),
        .idx  ({row_q[RB-1:0], col_lo}),
        .wdata(wdata),
        .rdata(rdata)
    );

endmodule

// File: rtl/dsf_checker.sv
// Property checker for dram_strobe_frontend, attached by bind below.
// Assumes: observes the top's ports plus the refresh counter and its step.
module dsf_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cycle_type,
    input logic [1:0]        lane_oe,
    input logic [1:0]        lane_we,
    input logic [ADDR_W-1:0] row_q,
    input logic [ADDR_W-1:0] rfsh_row,
    input logic              rfsh_step
);

    assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_type != 3'd0 && $past(cycle_type) != 3'd0) |-> $stable(row_q));

    assert_read_needs_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_oe) |-> cycle_type == 3'd2);

    assert_write_pulse_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we[0] |=> !lane_we[0]);

    assert_write_pulse_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lane_we[1] |=> !lane_we[1]);

    assert_write_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |-> cycle_type == 3'd3);

    assert_refresh_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_type == 3'd4) |-> (lane_oe == 2'b00 && lane_we == 2'b00));

    assert_refresh_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_step |=> rfsh_row == ADDR_W'($past(rfsh_row) + 1'b1));

endmodule

bind dram_strobe_frontend dsf_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_type(cycle_type),
    .lane_oe   (lane_oe),
    .lane_we   (lane_we),
    .row_q     (row_q),
    .rfsh_row  (rfsh_row),
    .rfsh_step (rfsh_step)
);

// File: tb/dram_strobe_frontend_tb.sv
`timescale 1ns/1ps
module dram_strobe_frontend_tb;

    logic        clk = 0, rst_n = 0;
    logic        ras_n = 1, lcs_n = 1, ucs_n = 1, we_n = 1, oe_n = 1;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  lane_oe, lane_we;
    logic [2:0]  cycle_type;
    logic [9:0]  row_q, col_q;

    int checks = 0, fails = 0, wc0 = 0, wc1 = 0, rc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dram_strobe_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcs_n(lcs_n), .ucs_n(ucs_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata),
        .lane_oe(lane_oe), .lane_we(lane_we), .cycle_type(cycle_type),
        .row_q(row_q), .col_q(col_q)
    );

    // Count write pulses per lane, sampled away from the active edge.
    always @(negedge clk) begin
        if (lane_we[0]) wc0++;
        if (lane_we[1]) wc1++;
    end

    typedef struct packed {
        logic        wr;
        logic [1:0]  lanes;
        logic [9:0]  row;
        logic [9:0]  col;
        logic [15:0] data;
    } vec_t;

    // Array index = {row[1:0], col[1:0]}; read vectors carry expected data.
    localparam vec_t VECS [8] = '{
        '{1'b1, 2'b11, 10'h005, 10'h002, 16'hA1B2},
        '{1'b1, 2'b01, 10'h001, 10'h003, 16'h11CC},
        '{1'b1, 2'b10, 10'h001, 10'h003, 16'hEE22},
        '{1'b0, 2'b11, 10'h005, 10'h002, 16'hA1B2},
        '{1'b0, 2'b11, 10'h001, 10'h003, 16'hEECC},
        '{1'b0, 2'b01, 10'h3FD, 10'h1F6, 16'h00B2},
        '{1'b1, 2'b11, 10'h3FF, 10'h000, 16'h5A5A},
        '{1'b0, 2'b10, 10'h003, 10'h200, 16'h5A00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        logic [15:0] m;
        m = {{8{v.lanes[1]}}, {8{v.lanes[0]}}};
        wc0 = 0; wc1 = 0;
        addr = v.row; ras_n = 0;
        settle();
        chk("R2 row capture", row_q, v.row);
        addr = v.col;
        if (v.wr) begin wdata = v.data; we_n = 0; end
        else oe_n = 0;
        lcs_n = ~v.lanes[0]; ucs_n = ~v.lanes[1];
        settle();
        chk("R3 col capture", col_q, v.col);
        chk(v.wr ? "R6 write cycle" : "R5 read cycle", cycle_type, v.wr ? 3 : 2);
        chk("R4 lane_oe gating", lane_oe, v.wr ? 2'b00 : v.lanes);
        chk("R4 lane_we pulses", {wc1[15:0], wc0[15:0]},
            v.wr ? {15'd0, v.lanes[1], 15'd0, v.lanes[0]} : 32'd0);
        if (!v.wr) chk("R5 read data", rdata & m, v.data & m);
        lcs_n = 1; ucs_n = 1; we_n = 1; oe_n = 1;
        settle();
        ras_n = 1;
        settle();
    endtask

    task automatic refresh(input bit check, input logic [9:0] exp_row);
        addr = 10'h155; ras_n = 0;
        settle();
        if (check) begin
            chk("R7 refresh cycle", cycle_type, 3'd4);
            chk("R7 R9 refresh row", row_q, exp_row);
        end
        ras_n = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cycle", cycle_type, 3'd0);
        chk("R1 lane_oe", lane_oe, 2'b00);
        chk("R1 lane_we", lane_we, 2'b00);
        chk("R1 row_q", row_q, 10'd0);
        chk("R1 col_q", col_q, 10'd0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R3 merged strobe: first fall captures, last rise ends.
        addr = 10'h0AA; ras_n = 0; settle();
        oe_n = 0; addr = 10'h011; lcs_n = 0; settle();
        addr = 10'h3EE; ucs_n = 0; settle();
        chk("R3 first-fall column kept", col_q, 10'h011);
        chk("R4 both lanes driven", lane_oe, 2'b11);
        lcs_n = 1; settle();
        chk("R3 still read after first rise", cycle_type, 3'd2);
        chk("R4 upper lane only", lane_oe, 2'b10);
        ucs_n = 1; oe_n = 1; settle();
        chk("R10 row open after last rise", cycle_type, 3'd1);
        chk("R3 lanes off after last rise", lane_oe, 2'b00);

        // R6 write enable falling after strobes; data sampled then.
        ras_n = 1; settle();
        addr = 10'h002; ras_n = 0; settle();
        addr = 10'h001; lcs_n = 0; ucs_n = 0; settle();
        chk("R10 strobe without we/oe", cycle_type, 3'd1);
        wc0 = 0; wc1 = 0;
        wdata = 16'h1234; we_n = 0; settle();
        chk("R6 late-we pulses", {wc1[15:0], wc0[15:0]}, 32'h0001_0001);
        wdata = 16'hFFFF; settle();
        chk("R6 single pulse", {wc1[15:0], wc0[15:0]}, 32'h0001_0001);
        we_n = 1; lcs_n = 1; ucs_n = 1; settle();
        oe_n = 0; addr = 10'h001; lcs_n = 0; ucs_n = 0; settle();
        chk("R6 data sampled at fire", rdata, 16'h1234);
        oe_n = 1; lcs_n = 1; ucs_n = 1; settle();
        ras_n = 1; settle();

        // R7 R8 R9 CAS-before-RAS refresh.
        lcs_n = 0; settle();
        wc0 = 0; wc1 = 0;
        addr = 10'h155; ras_n = 0; settle();
        chk("R7 refresh cycle", cycle_type, 3'd4);
        chk("R7 address ignored", row_q, 10'd0);
        oe_n = 0; we_n = 0; settle();
        chk("R8 no lane drive", lane_oe, 2'b00);
        chk("R8 no write", {wc1[15:0], wc0[15:0]}, 32'd0);
        oe_n = 1; we_n = 1; ras_n = 1; settle();
        rc = 1;
        refresh(1, 10'd1); rc++;
        for (int k = 0; k < 1021; k++) begin refresh(0, 10'd0); rc++; end
        refresh(1, 10'd1023);
        refresh(1, 10'd0);
        lcs_n = 1; settle();
        chk("R1 idle after refresh", cycle_type, 3'd0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule